// File: doc/BRIEF.md
# Supply-Loss Guard for a Byte-Wide Static RAM

This block sits between the bus pins of a byte-wide static RAM and its storage array. It decodes the active-low chip-select, output-enable and write-strobe pins into three internal controls: a read strobe, a write strobe and the enable for the data-bus drivers. It also watches three digitised supply-status flags. These say whether the supply is below the upper deselect threshold, below the lower deselect threshold, or below the battery switchover level.

A power-state machine has priority over the bus decode. While the supply is out of tolerance, every internal control is held inactive and the pins are ignored. Below the switchover level, the battery is selected to hold the array. When the supply is good again, the machine keeps the array write-protected for a fixed recovery period, counted in clock cycles, before normal access resumes.

An internal write lasts from the later falling edge of chip select and write strobe to the earlier rising edge of the two. A write opens only on a fresh start. Strobes that are already low when protection lifts, or when reset is released, cause no write until one of them has gone high. All control pins and status flags are plain level signals. The block has no streaming data interface.

Top module: `pfsram_guard`

## Requirements
- R1: With `ce_n` high at a clock edge, `arr_rd`, `arr_wr` and `dq_oe` are all 0 after that edge, whatever `oe_n` and `we_n` are.
- R2: With the state NORMAL and `ce_n` and `we_n` both low at an edge, `arr_wr` is 1 and `dq_oe` is 0 after that edge, whatever `oe_n` is, provided the write opened as R4 describes.
- R3: With the state NORMAL, `ce_n` low and `we_n` high at an edge, `arr_rd` is 1 after that edge. `dq_oe` equals the inverse of `oe_n`. If `we_n` falls while the output is driving, `dq_oe` drops after the next edge.
- R4: The write window opens at the first edge where `ce_n` and `we_n` are both low, after an edge where they were not both low. It closes at the first edge where either is high. Strobes held low through reset, or through a protected period, do not open a write.
- R5: Pin decoding has a latency of one clock edge, so an output reflects the pins sampled at the previous rising edge.
- R6: In any state other than NORMAL, `arr_rd`, `arr_wr` and `dq_oe` are 0 in the same cycle, for every combination of pins.
- R7: Each status flag passes through a two-stage synchroniser, so a change applied before edge 1 first affects `pwr_state` after edge 3.
- R8: `pwr_state` encodes NORMAL=0, PROTECT=1, BATTERY=2, RECOVER=3. Reset gives PROTECT. From NORMAL or RECOVER, the machine goes to PROTECT when either the below-upper flag or the below-lower flag is set.
- R9: From PROTECT or RECOVER, the machine goes to BATTERY when the below-switchover flag is set. It returns from BATTERY to PROTECT when that flag clears. `bat_sel` is 1 exactly while the state is BATTERY.
- R10: From PROTECT, when all three flags are clear, the machine goes to RECOVER. It stays there for exactly `REC_CYCLES` cycles and then goes to NORMAL.
- R11: A fall back into the deselect window during RECOVER returns the machine to PROTECT. The next recovery then lasts the full `REC_CYCLES` cycles again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_below_upper | input | 1 | Supply below upper deselect threshold (asynchronous) |
| sup_below_lower | input | 1 | Supply below lower deselect threshold (asynchronous) |
| sup_below_bat | input | 1 | Supply below battery switchover level (asynchronous) |
| ce_n | input | 1 | Chip select pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write strobe pin, active low |
| arr_rd | output | 1 | Internal read strobe to the array |
| arr_wr | output | 1 | Internal write strobe to the array |
| dq_oe | output | 1 | Data-bus driver enable |
| bat_sel | output | 1 | 1 selects battery supply, 0 selects main supply |
| pwr_state | output | 2 | Power state: 0 NORMAL, 1 PROTECT, 2 BATTERY, 3 RECOVER |

## Verification
The assertions assume that the bus pins are synchronous to `clk`, and that the status flags are physically consistent: below the switchover level implies below both thresholds. They also assume that each flag holds for more than the synchroniser depth when it is meant to take effect. The stimulus changes pins and flags only on falling clock edges. It always moves the flags in consistent combinations and holds each supply condition for several cycles. The pin decode is swept over every combination of the three pins, in both the protected and the normal state.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BATTERY = 2'd2,
    ST_RECOVER = 2'd3
  } pfs_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int W       = 3,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_V}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfs_pwr_fsm.sv
module pfs_pwr_fsm
  import pfsram_pkg::*;
#(
  parameter int REC_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       desel,
  input  logic       below_bat,
  output pfs_state_e state,
  output logic       bat_sel
);
  localparam int CNT_W = (REC_CYCLES < 2) ? 1 : $clog2(REC_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

  pfs_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_NORMAL: if (desel || below_bat) st_d = ST_PROTECT;
      ST_PROTECT: begin
        if (below_bat) st_d = ST_BATTERY;
        else if (!desel) begin
          st_d  = ST_RECOVER;
          cnt_d = '0;
        end
      end
      ST_BATTERY: if (!below_bat) st_d = ST_PROTECT;
      ST_RECOVER: begin
        if (below_bat) st_d = ST_BATTERY;
        else if (desel) st_d = ST_PROTECT;
        else if (cnt_q == LAST) st_d = ST_NORMAL;
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PROTECT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state   = st_q;
  assign bat_sel = (st_q == ST_BATTERY);

  // R8: NORMAL is left only towards PROTECT
  p_normal_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL) |=> (st_q == ST_NORMAL || st_q == ST_PROTECT));
  // R10: NORMAL is entered only from a finished recovery
  p_normal_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_NORMAL) |-> ($past(st_q) == ST_RECOVER && $past(cnt_q) == LAST));
  // R9: battery state is left only towards PROTECT
  p_battery_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BATTERY) |=> (st_q == ST_BATTERY || st_q == ST_PROTECT));
  // R11: a counting recovery always came from recovery
  p_recover_cont_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOVER && cnt_q != '0) |-> ($past(st_q) == ST_RECOVER));
endmodule

// File: rtl/pfs_bus_decode.sv
module pfs_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_o,
  output logic wr_o,
  output logic oe_o
);
  logic both_low, bl_prev, wr_q, rd_q, drv_q;

  assign both_low = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_prev <= 1'b1;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      bl_prev <= both_low;
      wr_q    <= allow && both_low && (wr_q || !bl_prev);
      rd_q    <= !ce_n && we_n;
      drv_q   <= !ce_n && we_n && !oe_n;
    end
  end

  assign rd_o = rd_q && allow;
  assign wr_o = wr_q && allow;
  assign oe_o = drv_q && allow;

  // R4: a write only rises after a cycle with the strobes not both low
  p_fresh_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_q) |-> ($past(!ce_n && !we_n) && $past(ce_n || we_n, 2)));
  // R6: protection clears the write window for the next cycle
  p_protect_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> !wr_q);
  // R2: driver and write strobe never active together
  p_no_contention_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && oe_o));
  // R1: deselect at an edge leaves all outputs idle afterwards
  p_deselect_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!rd_o && !wr_o && !oe_o));
endmodule

// File: rtl/pfsram_guard.sv
module pfsram_guard
  import pfsram_pkg::*;
#(
  parameter int REC_CYCLES  = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_below_upper,
  input  logic       sup_below_lower,
  input  logic       sup_below_bat,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  output logic       arr_rd,
  output logic       arr_wr,
  output logic       dq_oe,
  output logic       bat_sel,
  output logic [1:0] pwr_state
);
  logic [2:0] flags_s;
  pfs_state_e st;
  logic       allow;

  pfs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sup_below_bat, sup_below_lower, sup_below_upper}),
    .q(flags_s)
  );

  pfs_pwr_fsm #(.REC_CYCLES(REC_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .desel(flags_s[0] || flags_s[1]),
    .below_bat(flags_s[2]),
    .state(st),
    .bat_sel(bat_sel)
  );

  assign allow     = (st == ST_NORMAL);
  assign pwr_state = st;

  pfs_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .allow(allow),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_o(arr_rd), .wr_o(arr_wr), .oe_o(dq_oe)
  );

  // R6: nothing reaches the array outside NORMAL
  p_guarded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0) |-> (!arr_rd && !arr_wr && !dq_oe));
  // R9: battery selection tracks the battery state
  p_bat_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel == (pwr_state == 2'd2));
endmodule

// File: tb/tb_pfsram_guard.sv
module tb_pfsram_guard;
  localparam int REC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b1, lo = 1'b1, bat = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic arr_rd, arr_wr, dq_oe, bat_sel;
  logic [1:0] pwr_state;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pfsram_guard #(.REC_CYCLES(REC)) dut (
    .clk(clk), .rst_n(rst_n),
    .sup_below_upper(up), .sup_below_lower(lo), .sup_below_bat(bat),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .arr_rd(arr_rd), .arr_wr(arr_wr), .dq_oe(dq_oe),
    .bat_sel(bat_sel), .pwr_state(pwr_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic outs(input string tag, input int rd, input int wr, input int oe);
    chk({tag, " rd"}, arr_rd, rd);
    chk({tag, " wr"}, arr_wr, wr);
    chk({tag, " oe"}, dq_oe, oe);
  endtask

  task automatic count_recover(input string tag);
    int n = 0;
    int guard = 0;
    while (pwr_state != 2'd3 && guard < 50) begin cyc(1); guard++; end
    while (pwr_state == 2'd3 && n < 10 * REC) begin cyc(1); n++; end
    chk(tag, n, REC);
    chk({tag, " normal"}, pwr_state, 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    // R8 reset state
    chk("R8 reset state", pwr_state, 1);
    chk("R9 reset bat_sel", bat_sel, 0);
    outs("R6 reset", 0, 0, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R9 battery entered", pwr_state, 2);
    chk("R9 bat_sel on", bat_sel, 1);
    // R7 synchroniser latency: clear battery flag only
    bat = 1'b0;
    cyc(2);
    chk("R7 no change after 2 edges", pwr_state, 2);
    cyc(1);
    chk("R7 change after 3 edges", pwr_state, 1);
    chk("R9 bat_sel off", bat_sel, 0);
    // R6 exhaustive pin sweep while protected
    for (int p = 0; p < 8; p++) begin
      {ce_n, oe_n, we_n} = 3'(p);
      cyc(1);
      outs($sformatf("R6 protect pins=%0d", p), 0, 0, 0);
    end
    // strobes held low through recovery: R4
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    up = 1'b0; lo = 1'b0;
    count_recover("R10 recovery length");
    cyc(1);
    outs("R4 held strobes no write", 0, 0, 0);
    we_n = 1'b1;
    cyc(1);
    outs("R3 read drives", 1, 0, 1);
    we_n = 1'b0;
    cyc(1);
    outs("R3 we falls drop driver R4 fresh write", 0, 1, 0);
    // exhaustive pin sweep in NORMAL from idle, R1 R2 R3 R5
    for (int p = 0; p < 8; p++) begin
      logic c, o, w;
      {c, o, w} = 3'(p);
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      cyc(1);
      ce_n = c; oe_n = o; we_n = w;
      chk($sformatf("R5 old value pins=%0d", p), arr_wr, 0);
      cyc(1);
      outs($sformatf("R1R2R3 pins=%0d", p), int'(!c && w), int'(!c && !w), int'(!c && w && !o));
      cyc(1);
      outs($sformatf("R1R2R3 held pins=%0d", p), int'(!c && w), int'(!c && !w), int'(!c && w && !o));
    end
    // R4 window: earlier rise closes, later fall opens
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    cyc(1);
    chk("R4 open", arr_wr, 1);
    ce_n = 1'b1;
    cyc(1);
    chk("R4 ce rise closes", arr_wr, 0);
    ce_n = 1'b0;
    cyc(1);
    chk("R4 ce later fall opens", arr_wr, 1);
    // R6 protection mid-write, same-cycle gating
    up = 1'b1;
    cyc(2);
    chk("R6 still normal", pwr_state, 0);
    chk("R6 write before protect", arr_wr, 1);
    cyc(1);
    chk("R8 protect on upper", pwr_state, 1);
    chk("R6 write cut", arr_wr, 0);
    // R11 restart
    up = 1'b0;
    while (pwr_state != 2'd3) cyc(1);
    cyc(5);
    lo = 1'b1;
    cyc(4);
    chk("R11 back to protect", pwr_state, 1);
    lo = 1'b0;
    count_recover("R11 full recovery again");
    cyc(1);
    chk("R4 no write after recovery", arr_wr, 0);
    // R9 from NORMAL straight to battery
    ce_n = 1'b1; we_n = 1'b1;
    up = 1'b1; lo = 1'b1; bat = 1'b1;
    cyc(3);
    chk("R8 normal to protect", pwr_state, 1);
    cyc(1);
    chk("R9 protect to battery", pwr_state, 2);
    chk("R9 bat_sel", bat_sel, 1);
    bat = 1'b0;
    cyc(3);
    chk("R9 battery to protect", pwr_state, 1);
    cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule